// File: doc/BRIEF.md
# Reconfigurable Multiplexer-Tree Perfect Hash

This block maps a reduced lookup key of `KEY_W` bits to a dense index of `IDX_W` bits. For a suitable key set of up to 2^`IDX_W` members, every key gets its own index. The hash is a tree of multiplexer nodes. Each node forms one or more select bits, and each select bit is the XOR of a chosen subset of key bits. The select bits a node produces become the top bits of that node's encoding. Its remaining bits are the encoding of the child the select bits point at. The index is therefore built up from the root downward, one group of select bits per tree level.

The subset of key bits behind every select bit is held in a mask register. Software writes these registers one per cycle through an addressed write port, so a new key set needs new masks and no new hardware. The parameter `SEL_W` picks the tree form. With `SEL_W = 1` the tree is binary: every node is a two-way multiplexer. With `SEL_W` from 2 to 5, every node is a 2^`SEL_W`-way multiplexer driven by `SEL_W` select bits. The parameter `OUT_REG` adds a register at the output.

Top module: `mux_tree_hash`

## Requirements
- R1: The index is `IDX_W` bits wide (`IDX_W` a multiple of `SEL_W`) and is formed by a tree of `IDX_W/SEL_W` levels. A node's encoding is its own select bits on top, followed by the encoding of the child those select bits pick. The root's encoding is the index.
- R2: A select bit equals the XOR reduction of the key ANDed with that select bit's mask. A mask of all zeros gives 0, and a mask with several bits set gives the XOR of those key bits.
- R3: In the binary form (`SEL_W = 1`), a node with select 0 takes child 2j, and a node with select 1 takes child 2j+1, where j is the node's own number within its level.
- R4: In the wide form, a node's select bits form a number s, with the bit from the node's first mask as bit 0. The node takes child j*2^`SEL_W` + s.
- R5: Mask addresses are assigned level by level starting at the root (level 0). The mask of select bit b of node j on level d is at address base(d) + j*`SEL_W` + b, where base(d) is the number of masks on all levels above d.
- R6: When `cfg_we_i` is high at a rising edge and `cfg_addr_i` is in range, `cfg_mask_i` replaces that mask, and the index uses it from the next cycle on. While `cfg_we_i` is low, all masks hold their values.
- R7: A write to an address at or above the number of masks changes no mask.
- R8: Reset (`rst_ni` low) clears every mask and the output register, so the index is 0 for every key until masks are written.
- R9: With `OUT_REG = 1`, the index shows the key sampled at the previous rising edge. With `OUT_REG = 0`, the index follows the key in the same cycle.
- R10: With masks chosen for a key set, the keys of that set map to distinct indices, covering all 2^`IDX_W` values when the set is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| key_i | input | KEY_W | Reduced key to hash |
| cfg_we_i | input | 1 | Mask write enable |
| cfg_addr_i | input | CFG_AW | Mask number to write |
| cfg_mask_i | input | KEY_W | New mask value |
| idx_o | output | IDX_W | Hash index |

## Verification
Two instances are tried side by side: a binary tree with a registered output, and a four-way tree with a combinational output. First, single-mask probes run from the reset state, with all other masks at zero. These show which address drives which node and which bit of the index, and they separate the two-way and four-way child selection. Next, a full sixteen-key set is hashed. The masks for this set mix single-bit selects with multi-bit XOR selects, and the set is built so that a wrong child choice, a wrong mask address or a wrong XOR gives a repeated index. Finally, out-of-range writes, key changes within a cycle and the reset state show the write decode, the output latency and the cleared state.

// File: rtl/hash_tree_pkg.sv
package hash_tree_pkg;

  // Number of select masks on all levels above level d of a tree whose
  // nodes each use r select bits (level 0 is the root).
  function automatic int mask_base(input int d, input int r);
    return r * ((2 ** (r * d)) - 1) / ((2 ** r) - 1);
  endfunction

  // Parity of a key slice already gated by its mask (keys up to 64 bits).
  function automatic logic gated_parity(input logic [63:0] gated);
    return ^gated;
  endfunction

endpackage

// File: rtl/hash_mask_bank.sv
module hash_mask_bank #(
  parameter int KEY_W    = 16,
  parameter int NUM_MASK = 15,
  parameter int AW       = 4
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               we_i,
  input  logic [AW-1:0]                      addr_i,
  input  logic [KEY_W-1:0]                   wdata_i,
  output logic [NUM_MASK-1:0][KEY_W-1:0]     masks_o
);

  logic [NUM_MASK-1:0][KEY_W-1:0] masks_q;
  logic                           addr_ok;
  logic                           wr_hit;

  assign addr_ok = (32'(addr_i) < NUM_MASK);
  assign wr_hit  = we_i && addr_ok;

  for (genvar i = 0; i < NUM_MASK; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        masks_q[i] <= '0;
      end else if (wr_hit && (32'(addr_i) == i)) begin
        masks_q[i] <= wdata_i;
      end
    end
  end

  assign masks_o = masks_q;

  AST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hit |=> masks_q[$past(addr_i)] == $past(wdata_i)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(masks_q)); // R6

  AST_RANGE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !addr_ok) |=> $stable(masks_q)); // R7

endmodule

// File: rtl/hash_leaf.sv
module hash_leaf
  import hash_tree_pkg::*;
#(
  parameter int KEY_W = 16,
  parameter int SEL_W = 1
) (
  input  logic [KEY_W-1:0]              key_i,
  input  logic [SEL_W-1:0][KEY_W-1:0]   mask_i,
  output logic [SEL_W-1:0]              enc_o
);

  always_comb begin
    for (int b = 0; b < SEL_W; b++) begin
      enc_o[b] = gated_parity(64'(key_i & mask_i[b]));
    end
  end

endmodule

// File: rtl/hash_node.sv
module hash_node
  import hash_tree_pkg::*;
#(
  parameter int KEY_W   = 16,
  parameter int SEL_W   = 1,
  parameter int CHILD_W = 1
) (
  input  logic [KEY_W-1:0]                       key_i,
  input  logic [SEL_W-1:0][KEY_W-1:0]            mask_i,
  input  logic [(2**SEL_W)-1:0][CHILD_W-1:0]     child_i,
  output logic [SEL_W+CHILD_W-1:0]               enc_o
);

  logic [SEL_W-1:0] sel;

  always_comb begin
    for (int b = 0; b < SEL_W; b++) begin
      sel[b] = gated_parity(64'(key_i & mask_i[b]));
    end
  end

  assign enc_o = {sel, child_i[sel]};

endmodule

// File: rtl/mux_tree_hash.sv
module mux_tree_hash
  import hash_tree_pkg::*;
#(
  parameter int KEY_W   = 16,
  parameter int IDX_W   = 4,
  parameter int SEL_W   = 1,
  parameter bit OUT_REG = 1'b1,
  parameter int CFG_AW  = $clog2(mask_base(IDX_W / SEL_W, SEL_W))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [KEY_W-1:0]  key_i,
  input  logic              cfg_we_i,
  input  logic [CFG_AW-1:0] cfg_addr_i,
  input  logic [KEY_W-1:0]  cfg_mask_i,
  output logic [IDX_W-1:0]  idx_o
);

  localparam int LEVELS   = IDX_W / SEL_W;
  localparam int FAN      = 2 ** SEL_W;
  localparam int NUM_MASK = mask_base(LEVELS, SEL_W);

  logic [NUM_MASK-1:0][KEY_W-1:0] mask_bus;
  logic [IDX_W-1:0]               comb_idx;

  hash_mask_bank #(
    .KEY_W    (KEY_W),
    .NUM_MASK (NUM_MASK),
    .AW       (CFG_AW)
  ) u_masks (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .addr_i  (cfg_addr_i),
    .wdata_i (cfg_mask_i),
    .masks_o (mask_bus)
  );

  // Levels are built from the leaves (e = 0) up to the root (e = LEVELS-1),
  // so each level reads encodings of the level declared before it.
  for (genvar e = 0; e < LEVELS; e++) begin : g_lvl
    localparam int DEPTH = LEVELS - 1 - e;
    localparam int NODES = 2 ** (SEL_W * DEPTH);
    localparam int OW    = SEL_W * (e + 1);
    localparam int MBASE = mask_base(DEPTH, SEL_W);

    logic [NODES-1:0][OW-1:0] enc;

    for (genvar j = 0; j < NODES; j++) begin : g_node
      if (e == 0) begin : g_leaf
        hash_leaf #(
          .KEY_W (KEY_W),
          .SEL_W (SEL_W)
        ) u_leaf (
          .key_i  (key_i),
          .mask_i (mask_bus[MBASE + j*SEL_W +: SEL_W]),
          .enc_o  (enc[j])
        );
      end else begin : g_inner
        hash_node #(
          .KEY_W   (KEY_W),
          .SEL_W   (SEL_W),
          .CHILD_W (SEL_W * e)
        ) u_node (
          .key_i   (key_i),
          .mask_i  (mask_bus[MBASE + j*SEL_W +: SEL_W]),
          .child_i (g_lvl[e-1].enc[j*FAN +: FAN]),
          .enc_o   (enc[j])
        );
      end
    end
  end

  assign comb_idx = g_lvl[LEVELS-1].enc[0];

  if (OUT_REG) begin : g_oreg
    logic [IDX_W-1:0] idx_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) idx_q <= '0;
      else         idx_q <= comb_idx;
    end
    assign idx_o = idx_q;
  end else begin : g_ocomb
    assign idx_o = comb_idx;
  end

  AST_IDX_DETERMINISTIC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(key_i) && ($past(key_i, 2) == $past(key_i)) &&
     !$past(cfg_we_i) && !$past(cfg_we_i, 2)) |-> $stable(idx_o)); // R9

  AST_CLEAR_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (idx_o == '0)); // R8

endmodule

// File: tb/mux_tree_hash_test.sv
module mux_tree_hash_test;

  localparam int KW = 16;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [KW-1:0] key = '0;
  logic          we_b = 1'b0, we_w = 1'b0;
  logic [3:0]    addr_b = '0, addr_w = '0;
  logic [KW-1:0] data_b = '0, data_w = '0;
  logic [IW-1:0] idx_b, idx_w;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mux_tree_hash #(.KEY_W(KW), .IDX_W(IW), .SEL_W(1), .OUT_REG(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .key_i(key), .cfg_we_i(we_b),
    .cfg_addr_i(addr_b), .cfg_mask_i(data_b), .idx_o(idx_b));

  mux_tree_hash #(.KEY_W(KW), .IDX_W(IW), .SEL_W(2), .OUT_REG(1'b0)) uut_wide (
    .clk_i(clk), .rst_ni(rst_n), .key_i(key), .cfg_we_i(we_w),
    .cfg_addr_i(addr_w), .cfg_mask_i(data_w), .idx_o(idx_w));

  // Mask tables for the 16-key set: binary tree (15 masks), four-way tree (10).
  localparam logic [KW-1:0] BIN_MASKS [15] = '{
    16'h0801, 16'h0002, 16'h2000, 16'h0004, 16'h0040, 16'h0008, 16'h0100,
    16'h0008, 16'h0008, 16'h0008, 16'h0008, 16'h0200, 16'h0200, 16'h0200, 16'h0200};
  localparam logic [KW-1:0] WIDE_MASKS [10] = '{
    16'h0801, 16'h0020, 16'h0004, 16'h0008, 16'h0004, 16'h0008,
    16'h0004, 16'h0008, 16'h0040, 16'h0100};

  // Key v: low byte holds v and XOR mixes of its bits, high byte repeats it.
  function automatic logic [KW-1:0] make_key(input int v);
    logic [7:0] lo;
    lo[3:0] = 4'(v);
    lo[4] = lo[0] ^ lo[3];
    lo[5] = lo[1] ^ lo[2];
    lo[6] = lo[2] ^ lo[0];
    lo[7] = lo[3] ^ lo[1];
    return {lo, lo} ^ 16'hA5C3;
  endfunction

  // Index model as a walk from the root: at each level the select bits are
  // appended to the index and pick the node to visit on the next level.
  function automatic int walk(input logic [KW-1:0] k, input logic [KW-1:0] m [15],
                              input int r);
    int idx = 0;
    int node = 0;
    int base = 0;
    for (int lvl = 0; lvl < IW / r; lvl++) begin
      int s = 0;
      for (int b = 0; b < r; b++) begin
        if (^(k & m[base + node*r + b])) s = s | (1 << b);
      end
      idx = (idx << r) | s;
      base = base + r * (1 << (r * lvl));
      node = node * (1 << r) + s;
    end
    return idx;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_both(input int ab, input logic [KW-1:0] db,
                            input int aw, input logic [KW-1:0] dw);
    @(negedge clk);
    we_b = (ab >= 0); addr_b = 4'(ab); data_b = db;
    we_w = (aw >= 0); addr_w = 4'(aw); data_w = dw;
    @(negedge clk);
    we_b = 1'b0; we_w = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin : main
    logic [KW-1:0] bm [15];
    logic [KW-1:0] wm [15];
    int seen_b [16];
    int seen_w [16];
    int exp_b, exp_w;

    // R8: reset state, masks cleared, index zero for a nonzero key
    key = 16'h1234;
    repeat (3) @(negedge clk);
    check("R8 reset binary", idx_b, 0);
    check("R8 reset wide", idx_w, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R2 zero masks binary", idx_b, 0);
    check("R2 zero masks wide", idx_w, 0);

    // R5 R3: binary root mask at address 0 drives index bit 3
    // R4: wide root select bit 1 at address 1; s = 2 gives index 8
    key = 16'h0001;
    write_both(0, 16'h0001, 1, 16'h0001);
    @(negedge clk);
    check("R5 binary root address", idx_b, 8);
    check("R4 wide root bit1", idx_w, 8);

    // R4 R5: wide node 2 (addresses 6,7) selected; mask bit0 there adds 1
    write_both(-1, 16'h0, 6, 16'h0001);
    check("R4 wide child node2", idx_w, 9);
    // R3: binary level-1 node 1 is address 2; mask there adds 4
    write_both(2, 16'h0001, -1, 16'h0);
    @(negedge clk);
    check("R3 binary child node1", idx_b, 12);

    // R9: key change mid-cycle: wide follows at once, binary one edge later
    @(negedge clk);
    key = 16'h0000;
    #1;
    check("R9 comb output follows", idx_w, 0);
    check("R9 registered output holds", idx_b, 12);
    @(posedge clk); #1;
    check("R9 registered output updates", idx_b, 0);

    // Load full mask sets
    for (int i = 0; i < 15; i++) begin
      bm[i] = BIN_MASKS[i];
      wm[i] = (i < 10) ? WIDE_MASKS[i] : 16'h0;
      write_both(i, BIN_MASKS[i], (i < 10) ? i : -1, (i < 10) ? WIDE_MASKS[i] : 16'h0);
    end
    for (int i = 0; i < 16; i++) begin
      seen_b[i] = 0; seen_w[i] = 0;
    end

    // R1 R2 R10: walk the key table
    for (int v = 0; v < 16; v++) begin
      @(negedge clk);
      key = make_key(v);
      @(posedge clk); #1;
      exp_b = walk(key, bm, 1);
      exp_w = walk(key, wm, 2);
      check("R1 R2 binary index", idx_b, exp_b);
      check("R1 R2 wide index", idx_w, exp_w);
      seen_b[idx_b]++;
      seen_w[idx_w]++;
    end
    for (int i = 0; i < 16; i++) begin
      check("R10 binary distinct", seen_b[i], 1);
      check("R10 wide distinct", seen_w[i], 1);
    end

    // R7: writes past the last mask leave every index unchanged
    write_both(15, 16'hFFFF, 12, 16'hFFFF);
    write_both(-1, 16'h0, 10, 16'hFFFF);
    for (int v = 0; v < 16; v += 5) begin
      @(negedge clk);
      key = make_key(v);
      @(posedge clk); #1;
      check("R7 binary out of range", idx_b, walk(key, bm, 1));
      check("R7 wide out of range", idx_w, walk(key, wm, 2));
    end

    // R6: idle cycles keep masks, then a new root mask takes effect
    key = make_key(6);
    repeat (4) @(negedge clk);
    check("R6 hold binary", idx_b, walk(key, bm, 1));
    bm[0] = 16'h0000;
    write_both(0, 16'h0000, -1, 16'h0);
    @(negedge clk);
    check("R6 rewrite binary", idx_b, walk(key, bm, 1));

    // R8: reset again clears masks
    rst_n = 1'b0;
    @(negedge clk);
    check("R8 second reset binary", idx_b, 0);
    check("R8 second reset wide", idx_w, 0);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R8 masks cleared wide", idx_w, 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule